// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit decides where a 32-bit RISC core with fixed four-byte instructions goes next. It holds the program counter in a register that resets to address zero. From that PC, the current instruction word and the two source operand values, it produces the next PC combinationally. It also produces an optional link-register write, made up of a write strobe, a register index and a value.

Five kinds of control flow are resolved:

- absolute jumps and calls that splice a 26-bit index under the top four PC bits;
- PC-relative branches, one unconditional and six that compare two operands;
- jumps through a register, which cover return, exception return, break return and plain jump;
- a call through a register;
- a read of the sequential PC.

Every other instruction word simply advances by four. The PC register loads the computed next PC on a clock edge where `step_en` is high.

Top module: `npc_unit`

## Requirements
- R1: The asynchronous active-low reset forces `pc_q` to 0 at once. Release is synchronised, so `pc_q` stays 0 for two clock edges after `rst_n` rises.
- R2: Any primary opcode that is not listed below, and any extended code under primary opcode 0x3a that is not listed below, gives `npc = pc_q + 4` with `link_we = 0`. This includes opcode 0x3e.
- R3: Primary opcode 0x01 sets `npc = {pc_q[31:28], instr[31:6], 2'b00}` and writes no link.
- R4: Primary opcode 0x00 jumps to the same absolute target as R3. It asserts `link_we` with `link_idx = 31` and `link_val = pc_q + 4`.
- R5: Primary opcode 0x06 always branches to `pc_q + 4 + sign_extend(instr[21:6])`, with wrap-around modulo 2^32. A taken conditional branch uses the same target. A branch that is not taken gives `pc_q + 4`.
- R6: Signed compares of operand A (field `instr[31:27]`) against operand B (field `instr[26:22]`): opcode 0x0e branches when A >= B, and opcode 0x16 branches when A < B.
- R7: Unsigned compares: opcode 0x2e branches when A >= B, and opcode 0x36 branches when A < B.
- R8: Opcode 0x26 branches when A == B, and opcode 0x1e branches when A != B.
- R9: Under primary opcode 0x3a, extended codes 0x01, 0x05, 0x09 and 0x0d (field `instr[16:11]`) set `npc` to operand A, with no link.
- R10: Extended code 0x1d sets `npc` to operand A and links `pc_q + 4` into field C (`instr[21:17]`). Extended code 0x1c links `pc_q + 4` into C and gives `npc = pc_q + 4`.
- R11: A register field equal to 0 reads as zero, whatever value is on its operand input.
- R12: A link whose target index is 0 is suppressed, so `link_we = 0`.
- R13: On a rising edge with `step_en` high, `pc_q` takes the value `npc` had before the edge. With `step_en` low, `pc_q` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the PC register to `npc` on this edge |
| instr | input | 32 | Instruction word at `pc_q` |
| opnd_a | input | 32 | Value of the register named by field A |
| opnd_b | input | 32 | Value of the register named by field B |
| pc_q | output | 32 | Current program counter |
| npc | output | 32 | Next program counter (combinational) |
| link_we | output | 1 | Link-register write strobe |
| link_idx | output | 5 | Link-register index |
| link_val | output | 32 | Link value (PC + 4) |

## Verification
The next-PC path is combinational from `pc_q` and `instr`. A wrong decode or a wrong compare therefore shows on `npc` or on the link outputs in the same cycle as the instruction. A PC register that loads the wrong value, or loads when it should hold, shows on `pc_q` right after the advancing edge. That error also shifts every later sequential or relative target, because those targets are built from `pc_q`. The signed-versus-unsigned pair 0x7fffffff / 0x80000000 separates the two compare families. Field-zero operands expose any masking fault directly on `npc`.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    FL_SEQ = 2'd0,
    FL_ABS = 2'd1,
    FL_REL = 2'd2,
    FL_REG = 2'd3
  } flow_e;

  localparam logic [5:0] OP_CALL = 6'h00;
  localparam logic [5:0] OP_JMPI = 6'h01;
  localparam logic [5:0] OP_EXT  = 6'h3a;

  localparam logic [5:0] XO_ERET   = 6'h01;
  localparam logic [5:0] XO_RET    = 6'h05;
  localparam logic [5:0] XO_BRET   = 6'h09;
  localparam logic [5:0] XO_JMP    = 6'h0d;
  localparam logic [5:0] XO_NEXTPC = 6'h1c;
  localparam logic [5:0] XO_CALLR  = 6'h1d;

  // Branch condition: opcode bits [5:3] of an opcode ending in 3'b110
  localparam logic [2:0] CC_ALWAYS = 3'd0;
  localparam logic [2:0] CC_GE     = 3'd1;
  localparam logic [2:0] CC_LT     = 3'd2;
  localparam logic [2:0] CC_NE     = 3'd3;
  localparam logic [2:0] CC_EQ     = 3'd4;
  localparam logic [2:0] CC_GEU    = 3'd5;
  localparam logic [2:0] CC_LTU    = 3'd6;

  localparam logic [4:0] LINK_DEFAULT = 5'd31;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] opx,
  output flow_e      flow,
  output logic [2:0] cond,
  output logic       link_en,
  output logic       link_to_c
);

  always_comb begin
    flow      = FL_SEQ;
    cond      = CC_ALWAYS;
    link_en   = 1'b0;
    link_to_c = 1'b0;
    unique case (op)
      OP_CALL: begin
        flow    = FL_ABS;
        link_en = 1'b1;
      end
      OP_JMPI: flow = FL_ABS;
      OP_EXT: begin
        unique case (opx)
          XO_ERET, XO_RET, XO_BRET, XO_JMP: flow = FL_REG;
          XO_CALLR: begin
            flow      = FL_REG;
            link_en   = 1'b1;
            link_to_c = 1'b1;
          end
          XO_NEXTPC: begin
            link_en   = 1'b1;
            link_to_c = 1'b1;
          end
          default: flow = FL_SEQ;
        endcase
      end
      default: begin
        if (op[2:0] == 3'b110 && op[5:3] != 3'b111) begin
          flow = FL_REL;
          cond = op[5:3];
        end
      end
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   cond,
  output logic         taken
);

  logic s_lt;
  logic u_lt;
  logic eq;

  assign s_lt = $signed(a) < $signed(b);
  assign u_lt = a < b;
  assign eq   = a == b;

  always_comb begin
    unique case (cond)
      CC_ALWAYS: taken = 1'b1;
      CC_GE:     taken = !s_lt;
      CC_LT:     taken = s_lt;
      CC_NE:     taken = !eq;
      CC_EQ:     taken = eq;
      CC_GEU:    taken = !u_lt;
      CC_LTU:    taken = u_lt;
      default:   taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [W-1:0]     pc,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     reg_tgt,
  input  flow_e            flow,
  input  logic             taken,
  output logic [W-1:0]     pc_seq,
  output logic [W-1:0]     npc
);

  localparam int HI_W  = W - IDX_W - 2;
  localparam int EXT_W = W - IMM_W;

  logic [IMM_W-1:0] imm;
  logic [W-1:0]     rel_tgt;
  logic [W-1:0]     abs_tgt;

  assign imm     = idx[IMM_W-1:0];
  assign pc_seq  = pc + W'(4);
  assign rel_tgt = pc_seq + {{EXT_W{imm[IMM_W-1]}}, imm};
  assign abs_tgt = {pc[W-1 -: HI_W], idx, 2'b00};

  always_comb begin
    unique case (flow)
      FL_ABS:  npc = abs_tgt;
      FL_REL:  npc = taken ? rel_tgt : pc_seq;
      FL_REG:  npc = reg_tgt;
      default: npc = pc_seq;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          RIDX_W   = 5,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [31:0]       instr,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  output logic [W-1:0]      pc_q,
  output logic [W-1:0]      npc,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [W-1:0]      link_val
);

  localparam int NSRC  = 2;
  localparam int IDX_W = 26;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Source operands with register-zero masking
  logic [RIDX_W-1:0] src_idx [NSRC];
  logic [W-1:0]      src_raw [NSRC];
  logic [W-1:0]      src_val [NSRC];

  assign src_idx[0] = instr[31:27];
  assign src_idx[1] = instr[26:22];
  assign src_raw[0] = opnd_a;
  assign src_raw[1] = opnd_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_val[g] = (src_idx[g] == '0) ? '0 : src_raw[g];
  end

  // Decode, compare, target
  flow_e      flow;
  logic [2:0] cond;
  logic       link_en;
  logic       link_to_c;
  logic       taken;
  logic [W-1:0] pc_seq;

  npc_decode u_dec (
    .op        (instr[5:0]),
    .opx       (instr[16:11]),
    .flow      (flow),
    .cond      (cond),
    .link_en   (link_en),
    .link_to_c (link_to_c)
  );

  npc_cond #(.W(W)) u_cond (
    .a     (src_val[0]),
    .b     (src_val[1]),
    .cond  (cond),
    .taken (taken)
  );

  npc_target #(.W(W), .IMM_W(16), .IDX_W(IDX_W)) u_tgt (
    .pc      (pc_q),
    .idx     (instr[31:6]),
    .reg_tgt (src_val[0]),
    .flow    (flow),
    .taken   (taken),
    .pc_seq  (pc_seq),
    .npc     (npc)
  );

  // Link write
  assign link_idx = link_to_c ? instr[21:17] : LINK_DEFAULT;
  assign link_we  = link_en && (link_idx != '0);
  assign link_val = pc_seq;

  // PC register: next-state then register
  logic [W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (step_en) pc_d = npc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pc_q <= RESET_PC[W-1:0];
    else            pc_q <= pc_d;
  end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step_en,
  input logic [31:0] instr,
  input logic [31:0] pc_q,
  input logic [31:0] npc,
  input logic        link_we,
  input logic [4:0]  link_idx
);

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q));

  assert_advance_R13: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc_q == $past(npc));

  assert_no_zero_link_R12: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_idx != 5'd0);

  assert_call_links_ra_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[5:0] == 6'h00) |-> (link_we && link_idx == 5'd31));

  assert_abs_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[5:0] == 6'h01) |-> (npc[31:28] == pc_q[31:28] && npc[1:0] == 2'b00 && !link_we));

  assert_plain_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[5:0] == 6'h04) |-> (npc == pc_q + 32'd4 && !link_we));

  assert_zero_field_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[5:0] == 6'h3a && instr[16:11] == 6'h0d && instr[31:27] == 5'd0) |-> npc == 32'd0);

endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .step_en  (step_en),
  .instr    (instr),
  .pc_q     (pc_q),
  .npc      (npc),
  .link_we  (link_we),
  .link_idx (link_idx)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [31:0] instr;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] pc_q;
  logic [31:0] npc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  npc_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .instr    (instr),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .pc_q     (pc_q),
    .npc      (npc),
    .link_we  (link_we),
    .link_idx (link_idx),
    .link_val (link_val)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  fa;
    logic [4:0]  fb;
    logic [4:0]  fc;
    logic [5:0]  opx;
    logic [15:0] imm;
    logic [31:0] pc;
    logic [31:0] va;
    logic [31:0] vb;
    logic [31:0] enpc;
    logic        ewe;
    logic [4:0]  eidx;
    logic [31:0] eval;
    logic [23:0] tag;
  } row_t;

  localparam int NROWS = 26;
  localparam row_t ROWS [NROWS] = '{
    '{6'h00, 5'h12, 5'h05, 5'h0, 6'h00, 16'h1234, 32'hA000_0100, 32'h0, 32'h0, 32'hA914_48D0, 1'b1, 5'd31, 32'hA000_0104, "R4 "},
    '{6'h01, 5'h12, 5'h05, 5'h0, 6'h00, 16'h1234, 32'h5000_0000, 32'h0, 32'h0, 32'h5914_48D0, 1'b0, 5'd0, 32'h0, "R3 "},
    '{6'h06, 5'h00, 5'h00, 5'h0, 6'h00, 16'hFFF0, 32'h0000_0100, 32'h0, 32'h0, 32'h0000_00F4, 1'b0, 5'd0, 32'h0, "R5 "},
    '{6'h06, 5'h00, 5'h00, 5'h0, 6'h00, 16'h7FFC, 32'h0000_1000, 32'h0, 32'h0, 32'h0000_9000, 1'b0, 5'd0, 32'h0, "R5 "},
    '{6'h0e, 5'h01, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0214, 1'b0, 5'd0, 32'h0, "R6 "},
    '{6'h16, 5'h01, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0204, 1'b0, 5'd0, 32'h0, "R6 "},
    '{6'h2e, 5'h01, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0204, 1'b0, 5'd0, 32'h0, "R7 "},
    '{6'h36, 5'h01, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0214, 1'b0, 5'd0, 32'h0, "R7 "},
    '{6'h0e, 5'h01, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h0000_0005, 32'h0000_0005, 32'h0000_0214, 1'b0, 5'd0, 32'h0, "R6 "},
    '{6'h26, 5'h01, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h0000_1234, 32'h0000_1234, 32'h0000_0214, 1'b0, 5'd0, 32'h0, "R8 "},
    '{6'h1e, 5'h01, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h0000_1234, 32'h0000_1234, 32'h0000_0204, 1'b0, 5'd0, 32'h0, "R8 "},
    '{6'h1e, 5'h01, 5'h02, 5'h0, 6'h00, 16'hFFFC, 32'h0000_0200, 32'h0000_0001, 32'h0000_0002, 32'h0000_0200, 1'b0, 5'd0, 32'h0, "R8 "},
    '{6'h26, 5'h00, 5'h02, 5'h0, 6'h00, 16'h0010, 32'h0000_0200, 32'h0000_DEAD, 32'h0000_0000, 32'h0000_0214, 1'b0, 5'd0, 32'h0, "R11"},
    '{6'h3a, 5'h1f, 5'h00, 5'h0, 6'h05, 16'h0000, 32'h0000_0300, 32'h0000_4444, 32'h0, 32'h0000_4444, 1'b0, 5'd0, 32'h0, "R9 "},
    '{6'h3a, 5'h04, 5'h00, 5'h0, 6'h01, 16'h0000, 32'h0000_0300, 32'h0000_0008, 32'h0, 32'h0000_0008, 1'b0, 5'd0, 32'h0, "R9 "},
    '{6'h3a, 5'h04, 5'h00, 5'h0, 6'h09, 16'h0000, 32'h0000_0300, 32'h0000_000C, 32'h0, 32'h0000_000C, 1'b0, 5'd0, 32'h0, "R9 "},
    '{6'h3a, 5'h04, 5'h00, 5'h0, 6'h0d, 16'h0000, 32'h0000_0300, 32'hFFFF_FFF0, 32'h0, 32'hFFFF_FFF0, 1'b0, 5'd0, 32'h0, "R9 "},
    '{6'h3a, 5'h03, 5'h00, 5'h7, 6'h1d, 16'h0000, 32'h0000_0400, 32'h8000_0000, 32'h0, 32'h8000_0000, 1'b1, 5'd7, 32'h0000_0404, "R10"},
    '{6'h3a, 5'h00, 5'h00, 5'h9, 6'h1c, 16'h0000, 32'h0000_0500, 32'h0, 32'h0, 32'h0000_0504, 1'b1, 5'd9, 32'h0000_0504, "R10"},
    '{6'h3a, 5'h03, 5'h00, 5'h0, 6'h1d, 16'h0000, 32'h0000_0600, 32'h0000_2000, 32'h0, 32'h0000_2000, 1'b0, 5'd0, 32'h0, "R12"},
    '{6'h04, 5'h03, 5'h04, 5'h0, 6'h00, 16'h1111, 32'h0000_0700, 32'h1, 32'h2, 32'h0000_0704, 1'b0, 5'd0, 32'h0, "R2 "},
    '{6'h3a, 5'h03, 5'h04, 5'h5, 6'h31, 16'h0000, 32'h0000_0700, 32'h1, 32'h2, 32'h0000_0704, 1'b0, 5'd0, 32'h0, "R2 "},
    '{6'h3e, 5'h03, 5'h04, 5'h0, 6'h00, 16'h0040, 32'h0000_0700, 32'h1, 32'h2, 32'h0000_0704, 1'b0, 5'd0, 32'h0, "R2 "},
    '{6'h3a, 5'h00, 5'h00, 5'h0, 6'h0d, 16'h0000, 32'h0000_0800, 32'h0000_1234, 32'h0, 32'h0000_0000, 1'b0, 5'd0, 32'h0, "R11"},
    '{6'h06, 5'h00, 5'h00, 5'h0, 6'h00, 16'h0000, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0000_0000, 1'b0, 5'd0, 32'h0, "R5 "},
    '{6'h00, 5'h00, 5'h00, 5'h0, 6'h00, 16'h0000, 32'hF000_0000, 32'h0, 32'h0, 32'hF000_0000, 1'b1, 5'd31, 32'hF000_0004, "R4 "}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] build(input row_t r);
    if (r.op == 6'h3a) return {r.fa, r.fb, r.fc, r.opx, 5'd0, r.op};
    return {r.fa, r.fb, r.imm, r.op};
  endfunction

  // Register jump through field A = 1 to place the PC
  task automatic place_pc(input logic [31:0] where);
    instr   = {5'd1, 5'd0, 5'd0, 6'h0d, 5'd0, 6'h3a};
    opnd_a  = where;
    step_en = 1'b1;
    @(posedge clk); #1;
    step_en = 1'b0;
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    step_en = 1'b0;
    instr   = 32'h0000_0004;
    opnd_a  = '0;
    opnd_b  = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pc", pc_q, 32'h0);

    // Vector table
    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      r = ROWS[i];
      place_pc(r.pc);
      instr  = build(r);
      opnd_a = r.va;
      opnd_b = r.vb;
      #1;
      check({string'(r.tag), " npc"}, npc, r.enpc);
      check({string'(r.tag), " link_we"}, {31'd0, link_we}, {31'd0, r.ewe});
      if (r.ewe) begin
        check({string'(r.tag), " link_idx"}, {27'd0, link_idx}, {27'd0, r.eidx});
        check({string'(r.tag), " link_val"}, link_val, r.eval);
      end
      step_en = 1'b1;
      @(posedge clk); #1;
      step_en = 1'b0;
      check("R13 pc load", pc_q, r.enpc);
    end

    // R13: hold with step_en low
    place_pc(32'h0000_0A00);
    instr  = {5'd2, 5'd0, 5'd0, 6'h0d, 5'd0, 6'h3a};
    opnd_a = 32'h0000_0040;
    repeat (3) @(posedge clk);
    #1;
    check("R13 hold", pc_q, 32'h0000_0A00);
    check("R9 npc while holding", npc, 32'h0000_0040);

    // R1: asynchronous reset mid-run, synchronous release
    place_pc(32'h0000_1230);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear", pc_q, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    step_en = 1'b1;
    instr   = 32'h0000_0004;
    @(posedge clk); #1;
    check("R1 held after release edge 1", pc_q, 32'h0);
    @(posedge clk); #1;
    check("R1 held after release edge 2", pc_q, 32'h0);
    @(posedge clk); #1;
    step_en = 1'b0;
    check("R1 advance after release", pc_q, 32'h4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule